// File: doc/BRIEF.md
# Dual-Weight Table-Lookup Multiplier Lanes with Dot-Product Accumulator

This block multiplies unsigned 4-bit activations by signed 4-bit weights without any arithmetic multiplier. Each lane holds two constant weights that are fixed at elaboration. An elaboration-time function turns each weight pair into the contents of four small truth tables. Every table models a six-input lookup cell that is split into two five-input halves, so each table yields two product bits. A product is a single table read, addressed by the concatenation {weight-select, activation}.

Several lanes operate in parallel. Their products are registered behind a valid flag. A signed accumulator then sums the lane products of each valid beat into a dot product, and a start-of-vector flag restarts the sum. A neural-network datapath uses the block to apply one of two frozen weights per lane to a stream of activations, and the per-beat weight-select picks which weight applies.

Top module: `dwm_dot_unit`

## Requirements
- R1: For each lane i, one cycle after a beat with `in_valid`=1, `prod_out[8i+:8]` holds the 8-bit two's-complement product of the lane's weight and the unsigned activation `in_act[4i+:4]`. The weight is taken from `W1_VEC[4i+:4]` when `in_sel[i]`=1 and from `W0_VEC[4i+:4]` when `in_sel[i]`=0.
- R2: Product bits come in four pairs, pair j holding bits 2j and 2j+1. For the 5-bit index k = {sel, act}, bit 2j equals bit k of table j's 64-bit contents and bit 2j+1 equals bit 32+k. For lane 0 with weight 1 (sel=0) and weight -3 (sel=1), the tables for pairs 3, 2, 1, 0 contain 64'hfffe0000fffe0000, 64'h07fe0000f83e0000, 64'h39c6ff005a5af0f0 and 64'hccccccccaaaaaaaa.
- R3: `prod_valid` equals the `in_valid` of the previous cycle.
- R4: In a cycle with `in_valid`=0, `in_sel`, `in_act` and `in_first` are ignored, and `prod_out` keeps its value.
- R5: `acc_valid` follows `prod_valid` one cycle later. For a beat that had `in_first`=1, `acc_out` becomes the signed sum of that beat's lane products alone.
- R6: In a cycle in which `prod_valid`=0, `acc_out` keeps its value.
- R7: For a beat with `in_first`=0, `acc_out` becomes the previous `acc_out` plus the beat's signed lane sum, wrapping modulo 2^ACC_W.
- R8: While `rst_n`=0, `prod_valid`, `acc_valid`, `prod_out` and `acc_out` are all zero.
- R9: The extreme weights -8 and +7 at activation 15 give products -120 and +105 without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A beat is presented in this cycle |
| in_first | input | 1 | This beat starts a new dot product |
| in_sel | input | LANES | Per-lane weight select (1 picks the W1 weight) |
| in_act | input | 4*LANES | Unsigned activations, lane i at bits [4i+:4] |
| prod_valid | output | 1 | Registered products are valid |
| prod_out | output | 8*LANES | Signed products, lane i at bits [8i+:8] |
| acc_valid | output | 1 | Accumulator updated in the previous cycle |
| acc_out | output | ACC_W | Signed running dot product |

## Verification
The hardest state to reach is accumulator wraparound. The largest lane product is only about a hundred in magnitude, so a 16-bit sum needs well over a hundred beats of the most negative selection before it crosses the boundary. The stimulus picks a per-lane select pattern that makes every lane strongly negative at activation 15, then runs 120 beats in one vector so the sum passes -32768 and must land on a known wrapped value. A back-to-back burst with a restart in its middle covers the case where the restart flag arrives while the sum is still being updated.

// File: rtl/dwm_pkg.sv
// Package dwm_pkg
// Holds the geometry of the table-lookup multiplier and the elaboration-time
// function that fills one dual-output table from a weight pair.
// Assumes 4-bit signed weights, 4-bit unsigned activations, 8-bit products.
package dwm_pkg;
    localparam int ACT_W     = 4;
    localparam int WGT_W     = 4;
    localparam int PROD_W    = 8;
    localparam int IDX_W     = ACT_W + 1;
    localparam int HALF_SZ   = 1 << IDX_W;
    localparam int TBL_SZ    = 2 * HALF_SZ;
    localparam int TBL_PAIRS = PROD_W / 2;

    // Compute the contents of the table for product-bit pair `pair`.
    // The low half feeds bit 2*pair and the high half feeds bit 2*pair+1.
    // Index {sel, act}: sel=0 entries use w_lo, sel=1 entries use w_hi.
    function automatic logic [TBL_SZ-1:0] build_table(
        input logic signed [WGT_W-1:0] w_lo,
        input logic signed [WGT_W-1:0] w_hi,
        input int                      pair
    );
        logic [TBL_SZ-1:0] tbl;
        logic [PROD_W-1:0] pbits;
        int                wval;
        int                pval;
        tbl = '0;
        for (int idx = 0; idx < HALF_SZ; idx++) begin
            wval  = (idx >= (HALF_SZ / 2)) ? int'(w_hi) : int'(w_lo);
            pval  = wval * (idx % (HALF_SZ / 2));
            pbits = pval[PROD_W-1:0];
            tbl[idx]           = pbits[2*pair];
            tbl[HALF_SZ + idx] = pbits[2*pair+1];
        end
        return tbl;
    endfunction
endpackage

// File: rtl/dwm_table.sv
// Module dwm_table
// Model of a six-input lookup cell whose top input is tied high so that it
// acts as two five-input tables sharing one address. Each output is one bit
// of the contents INIT picked by the shared index.
// Assumes INIT is fixed at elaboration; contents never change at runtime.
module dwm_table
    import dwm_pkg::*;
#(
    parameter logic [TBL_SZ-1:0] INIT = '0
) (
    input  logic [IDX_W-1:0] addr,
    output logic             o_lo,
    output logic             o_hi
);
    // Read the lower half for the even bit and the upper half for the odd bit.
    always_comb begin
        o_lo = INIT[{1'b0, addr}];
        o_hi = INIT[{1'b1, addr}];
    end
endmodule

// File: rtl/dwm_core.sv
// Module dwm_core
// One lane's multiplier: four dual-output tables addressed by
// {sel, act}, each supplying two bits of the signed product.
// Assumes W_LO and W_HI are 4-bit two's-complement constants.
module dwm_core
    import dwm_pkg::*;
#(
    parameter logic signed [WGT_W-1:0] W_LO = 4'sd1,
    parameter logic signed [WGT_W-1:0] W_HI = -4'sd3
) (
    input  logic              sel,
    input  logic [ACT_W-1:0]  act,
    output logic [PROD_W-1:0] prod
);
    logic [IDX_W-1:0] idx;

    // Form the shared table address.
    always_comb idx = {sel, act};

    // One table per product-bit pair, contents computed at elaboration.
    for (genvar p = 0; p < TBL_PAIRS; p++) begin : g_pair
        localparam logic [TBL_SZ-1:0] PAIR_INIT = build_table(W_LO, W_HI, p);
        dwm_table #(
            .INIT (PAIR_INIT)
        ) u_tbl (
            .addr (idx),
            .o_lo (prod[2*p]),
            .o_hi (prod[2*p+1])
        );
    end
endmodule

// File: rtl/dwm_lane_array.sv
// Module dwm_lane_array
// LANES parallel table multipliers with a registered output stage. The
// products and the start flag are captured only on valid beats; the valid
// flag is registered every cycle.
// Assumes W0_VEC/W1_VEC pack lane i's weights at bits [4i+:4].
module dwm_lane_array
    import dwm_pkg::*;
#(
    parameter int                    LANES  = 4,
    parameter logic [WGT_W*LANES-1:0] W0_VEC = '0,
    parameter logic [WGT_W*LANES-1:0] W1_VEC = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_first,
    input  logic [LANES-1:0]          in_sel,
    input  logic [ACT_W*LANES-1:0]    in_act,
    output logic                      q_valid,
    output logic                      q_first,
    output logic [PROD_W*LANES-1:0]   q_prod
);
    localparam int PW = PROD_W * LANES;

    logic [PW-1:0] prod_c;

    // Instantiate one table multiplier per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dwm_core #(
            .W_LO (W0_VEC[WGT_W*l +: WGT_W]),
            .W_HI (W1_VEC[WGT_W*l +: WGT_W])
        ) u_core (
            .sel  (in_sel[l]),
            .act  (in_act[ACT_W*l +: ACT_W]),
            .prod (prod_c[PROD_W*l +: PROD_W])
        );
    end

    // Track beat validity one cycle behind the inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= in_valid;
    end

    // Capture products and start flag on valid beats only; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_prod  <= '0;
            q_first <= 1'b0;
        end else if (in_valid) begin
            q_prod  <= prod_c;
            q_first <= in_first;
        end
    end
endmodule

// File: rtl/dwm_accum.sv
// Module dwm_accum
// Adds the sign-extended lane products of each valid beat into a running
// ACC_W-bit sum, restarting from that beat's sum when the start flag is set.
// Assumes ACC_W >= 8; overflow wraps modulo 2^ACC_W.
module dwm_accum
    import dwm_pkg::*;
#(
    parameter int LANES = 4,
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    beat_valid,
    input  logic                    beat_first,
    input  logic [PROD_W*LANES-1:0] beat_prod,
    output logic                    acc_valid,
    output logic [ACC_W-1:0]        acc
);
    localparam int EXT = ACC_W - PROD_W;

    logic [ACC_W-1:0] lane_sum;
    logic [ACC_W-1:0] base;

    // Sum all lane products after sign extension to the accumulator width.
    always_comb begin
        lane_sum = '0;
        for (int l = 0; l < LANES; l++) begin
            lane_sum = lane_sum + {{EXT{beat_prod[PROD_W*l + PROD_W-1]}},
                                   beat_prod[PROD_W*l +: PROD_W]};
        end
    end

    // Choose the running value or zero as the base of the update.
    always_comb base = beat_first ? '0 : acc;

    // Update the sum on valid beats; flag the update one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            acc_valid <= 1'b0;
        end else begin
            acc_valid <= beat_valid;
            if (beat_valid) acc <= base + lane_sum;
        end
    end
endmodule

// File: rtl/dwm_dot_unit.sv
// Module dwm_dot_unit
// Top level: table-lookup multiplier lanes with registered products and a
// signed dot-product accumulator. Products appear one cycle after a beat,
// the accumulated sum one cycle after the products.
// Assumes weights are elaboration constants packed lane i at [4i+:4].
module dwm_dot_unit
    import dwm_pkg::*;
#(
    parameter int                     LANES  = 4,
    parameter int                     ACC_W  = 16,
    parameter logic [WGT_W*LANES-1:0] W0_VEC = 16'h5081,
    parameter logic [WGT_W*LANES-1:0] W1_VEC = 16'h8F7D
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic                      in_first,
    input  logic [LANES-1:0]          in_sel,
    input  logic [ACT_W*LANES-1:0]    in_act,
    output logic                      prod_valid,
    output logic [PROD_W*LANES-1:0]   prod_out,
    output logic                      acc_valid,
    output logic [ACC_W-1:0]          acc_out
);
    logic first_q;

    // Multiplier lanes and product register.
    dwm_lane_array #(
        .LANES  (LANES),
        .W0_VEC (W0_VEC),
        .W1_VEC (W1_VEC)
    ) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .in_sel   (in_sel),
        .in_act   (in_act),
        .q_valid  (prod_valid),
        .q_first  (first_q),
        .q_prod   (prod_out)
    );

    // Dot-product accumulator fed by the registered products.
    dwm_accum #(
        .LANES (LANES),
        .ACC_W (ACC_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (prod_valid),
        .beat_first (first_q),
        .beat_prod  (prod_out),
        .acc_valid  (acc_valid),
        .acc        (acc_out)
    );
endmodule

// File: rtl/dwm_dot_unit_chk.sv
// Module dwm_dot_unit_chk
// Property checker bound to dwm_dot_unit. Computes expected products with
// ordinary arithmetic and checks latency, holding and accumulation rules.
module dwm_dot_unit_chk
    import dwm_pkg::*;
#(
    parameter int                     LANES  = 4,
    parameter int                     ACC_W  = 16,
    parameter logic [WGT_W*LANES-1:0] W0_VEC = '0,
    parameter logic [WGT_W*LANES-1:0] W1_VEC = '0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_first,
    input logic [LANES-1:0]        in_sel,
    input logic [ACT_W*LANES-1:0]  in_act,
    input logic                    prod_valid,
    input logic [PROD_W*LANES-1:0] prod_out,
    input logic                    acc_valid,
    input logic [ACC_W-1:0]        acc_out
);
    logic [PROD_W*LANES-1:0] exp_prod;
    logic [ACC_W-1:0]        out_sum;
    logic                    first_seen;

    // Arithmetic reference product for every lane.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            logic signed [WGT_W-1:0] w;
            int                      p;
            w = in_sel[l] ? W1_VEC[WGT_W*l +: WGT_W] : W0_VEC[WGT_W*l +: WGT_W];
            p = int'(w) * int'({1'b0, in_act[ACT_W*l +: ACT_W]});
            exp_prod[PROD_W*l +: PROD_W] = p[PROD_W-1:0];
        end
    end

    // Signed sum of the products at the outputs.
    always_comb begin
        out_sum = '0;
        for (int l = 0; l < LANES; l++) begin
            out_sum = out_sum + ACC_W'($signed(prod_out[PROD_W*l +: PROD_W]));
        end
    end

    // Own record of whether the beat now at the outputs started a vector.
    always_ff @(posedge clk) begin
        if (!rst_n)        first_seen <= 1'b0;
        else if (in_valid) first_seen <= in_first;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        assert_lane_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> prod_out[PROD_W*l +: PROD_W] == $past(exp_prod[PROD_W*l +: PROD_W]));
    end

    assert_valid_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_valid);
    assert_valid_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !prod_valid);
    assert_prod_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prod_out));
    assert_acc_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid |=> acc_valid);
    assert_acc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_valid |=> !acc_valid);
    assert_acc_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && first_seen) |=> acc_out == $past(out_sum));
    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !prod_valid |=> $stable(acc_out));
    assert_acc_wrap_add_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid && !first_seen) |=> acc_out == ACC_W'($past(acc_out) + $past(out_sum)));
endmodule

bind dwm_dot_unit dwm_dot_unit_chk #(
    .LANES  (LANES),
    .ACC_W  (ACC_W),
    .W0_VEC (W0_VEC),
    .W1_VEC (W1_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_first   (in_first),
    .in_sel     (in_sel),
    .in_act     (in_act),
    .prod_valid (prod_valid),
    .prod_out   (prod_out),
    .acc_valid  (acc_valid),
    .acc_out    (acc_out)
);

// File: tb/dwm_dot_unit_test.sv
// Directed bench for dwm_dot_unit with default parameters (4 lanes, 16-bit sum).
module dwm_dot_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int ACC_W      = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic                in_first = 1'b0;
    logic [LANES-1:0]    in_sel = '0;
    logic [4*LANES-1:0]  in_act = '0;
    logic                prod_valid;
    logic [8*LANES-1:0]  prod_out;
    logic                acc_valid;
    logic [ACC_W-1:0]    acc_out;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic [ACC_W-1:0] exp_acc = '0;

    // Weights as given to the default parameters, lane 0 first.
    int W0 [LANES] = '{1, -8, 0, 5};
    int W1 [LANES] = '{-3, 7, -1, -8};
    // Documented table contents for lane 0, product-bit pairs 0..3.
    logic [63:0] LANE0_TBL [4] = '{64'hccccccccaaaaaaaa, 64'h39c6ff005a5af0f0,
                                   64'h07fe0000f83e0000, 64'hfffe0000fffe0000};

    dwm_dot_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_first   (in_first),
        .in_sel     (in_sel),
        .in_act     (in_act),
        .prod_valid (prod_valid),
        .prod_out   (prod_out),
        .acc_valid  (acc_valid),
        .acc_out    (acc_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int ref_prod(input int lane, input bit s, input int a);
        return (s ? W1[lane] : W0[lane]) * a;
    endfunction

    function automatic int lane_val(input int lane);
        return int'($signed(prod_out[8*lane +: 8]));
    endfunction

    // One isolated beat with full checking of products, valid flags and sum.
    task automatic do_beat(input logic [LANES-1:0] s, input logic [4*LANES-1:0] a, input bit first);
        int sum = 0;
        logic [8*LANES-1:0] snap;
        @(negedge clk);
        in_valid = 1'b1; in_first = first; in_sel = s; in_act = a;
        for (int l = 0; l < LANES; l++) sum += ref_prod(l, s[l], int'(a[4*l +: 4]));
        exp_acc = first ? ACC_W'(sum) : ACC_W'(exp_acc + ACC_W'(sum));
        @(negedge clk);
        in_valid = 1'b0; in_first = ~first; in_sel = ~s; in_act = ~a;
        chk(prod_valid == 1'b1, "R3 prod_valid after beat", prod_valid, 1);
        for (int l = 0; l < LANES; l++)
            chk(lane_val(l) == ref_prod(l, s[l], int'(a[4*l +: 4])), "R1 lane product",
                lane_val(l), ref_prod(l, s[l], int'(a[4*l +: 4])));
        snap = prod_out;
        @(negedge clk);
        chk(prod_valid == 1'b0, "R3 prod_valid idle", prod_valid, 0);
        chk(prod_out == snap, "R4 products held with ignored inputs", prod_out, snap);
        chk(acc_valid == 1'b1, "R5 acc_valid after products", acc_valid, 1);
        chk(acc_out == exp_acc, first ? "R5 restart sum" : "R7 accumulated sum",
            $signed(acc_out), $signed(exp_acc));
        @(negedge clk);
        chk(acc_valid == 1'b0, "R5 acc_valid idle", acc_valid, 0);
        chk(acc_out == exp_acc, "R6 sum held", $signed(acc_out), $signed(exp_acc));
        in_first = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(prod_valid == 0 && acc_valid == 0, "R8 valids in reset", {prod_valid, acc_valid}, 0);
        chk(prod_out == '0, "R8 products in reset", prod_out, 0);
        chk(acc_out == '0, "R8 sum in reset", acc_out, 0);
    endtask

    // All 32 {sel, act} combinations, every lane driven alike; lane 0 against tables.
    task automatic t_exhaustive();
        for (int k = 0; k < 32; k++) begin
            logic [4:0] idx = 5'(k);
            do_beat({LANES{idx[4]}}, {LANES{idx[3:0]}}, k == 0);
            for (int j = 0; j < 4; j++) begin
                chk(prod_out[2*j]   == LANE0_TBL[j][idx],      "R2 lane0 even bit", prod_out[2*j],   LANE0_TBL[j][idx]);
                chk(prod_out[2*j+1] == LANE0_TBL[j][32 + idx], "R2 lane0 odd bit",  prod_out[2*j+1], LANE0_TBL[j][32 + idx]);
            end
        end
    endtask

    // Extreme weights: lane 1 at -8 and +7, lane 3 at -8, activation 15.
    task automatic t_extremes();
        do_beat(4'b1000, 16'hFFFF, 1'b1);
        chk(lane_val(1) == -120, "R9 weight -8 times 15", lane_val(1), -120);
        chk(lane_val(3) == -120, "R9 lane3 weight -8 times 15", lane_val(3), -120);
        do_beat(4'b0010, 16'hFFFF, 1'b0);
        chk(lane_val(1) == 105, "R9 weight 7 times 15", lane_val(1), 105);
    endtask

    // Back-to-back beats with a restart in the middle.
    task automatic t_stream();
        logic [4*LANES-1:0] acts [6] = '{16'h1234, 16'hF0F0, 16'h9A5C, 16'h0F3E, 16'h7777, 16'hC1D2};
        logic [LANES-1:0]   sels [6] = '{4'h3, 4'hC, 4'h5, 4'hA, 4'hF, 4'h0};
        for (int b = 0; b < 6; b++) begin
            int sum = 0;
            @(negedge clk);
            in_valid = 1'b1; in_first = (b == 2); in_sel = sels[b]; in_act = acts[b];
            for (int l = 0; l < LANES; l++) sum += ref_prod(l, sels[b][l], int'(acts[b][4*l +: 4]));
            exp_acc = (b == 2) ? ACC_W'(sum) : ACC_W'(exp_acc + ACC_W'(sum));
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
        chk(lane_val(0) == ref_prod(0, sels[5][0], int'(acts[5][3:0])), "R1 last streamed lane0",
            lane_val(0), ref_prod(0, sels[5][0], int'(acts[5][3:0])));
        @(negedge clk);
        chk(acc_out == exp_acc, "R5 restart inside burst", $signed(acc_out), $signed(exp_acc));
    endtask

    // 120 beats of -300 each: -36000 wraps to 29536.
    task automatic t_wrap();
        for (int b = 0; b < 120; b++) do_beat(4'b1101, 16'hFFFF, b == 0);
        chk(acc_out == 16'd29536, "R7 wrap to 29536", acc_out, 29536);
    endtask

    // Reset in the middle of activity clears outputs.
    task automatic t_midreset();
        @(negedge clk);
        in_valid = 1'b1; in_sel = 4'hF; in_act = 16'hFFFF;
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        chk(prod_out == '0 && prod_valid == 0, "R8 products after mid reset", prod_out, 0);
        chk(acc_out == '0 && acc_valid == 0, "R8 sum after mid reset", acc_out, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_exhaustive();
        t_extremes();
        t_stream();
        t_wrap();
        t_midreset();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule